// File: doc/BRIEF.md
# Serialization Transfer Trigger Controller

This block decides the clock cycles in which a parallel-to-serial transfer engine begins a new frame. It watches the data word that waits to be serialized, an asynchronous hardware trigger pin and a busy indication from the engine. From these it produces a one-cycle start pulse. Three initiation modes are available: free-running, where a frame starts whenever the engine can take one; trigger-driven, where a chosen edge of the trigger pin starts a frame; and trigger-or-change, where either such an edge or a change of the data word since the last transmitted frame starts one. A fourth mode value holds the engine idle.

Several serializers can be chained so that one master initiates the frames. A serializer set as a slave in a chain passes every trigger it detects to its forwarded-trigger output, and the system wiring routes that output toward the master's trigger pin. Chaining cannot be combined with the alternate serialization-source mode. If both are selected, the block raises a configuration-error flag and issues no starts.

Top module: `xtc_trig_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `start_o`, `fwd_trig_o` and `cfg_err_o` are low. Reset clears the pending request, the trigger edge history and the last-transmitted word to zero, so after reset in mode 2 an all-zero `data_i` starts nothing.
- R2: `cfg_mode_i` = 0 (free-running): a start request is present on every cycle, so `start_o` pulses whenever the engine is idle and the previous cycle carried no start.
- R3: `cfg_mode_i` = 1 (trigger): a start requires an active edge on `trig_pin_i`. The edge is seen after a two-flop synchronizer, and the resulting `start_o` appears three clock edges after the edge is sampled. `cfg_trig_pol_i` = 0 selects the rising edge and 1 selects the falling edge.
- R4: With `cfg_trig_en_i` = 0, edges on `trig_pin_i` produce neither a start nor a forwarded trigger.
- R5: `cfg_mode_i` = 2 (trigger-or-change): a start is requested on an active trigger edge, or on any cycle where `data_i` differs from the word captured at the most recent start. Every start captures `data_i` as the new last-transmitted word.
- R6: `start_o` is never high in a cycle that follows a cycle with `eng_busy_i` high. A request that arrives while the engine is busy stays pending and is released on the first idle cycle.
- R7: With `cfg_chain_en_i` = 1 and `cfg_is_master_i` = 0, every enabled active trigger edge produces a one-cycle `fwd_trig_o` pulse, in the same cycle where a trigger start would appear.
- R8: `fwd_trig_o` stays low when chaining is disabled or when `cfg_is_master_i` = 1. A chained master treats its trigger pin as an ordinary trigger source.
- R9: When `cfg_chain_en_i` and `cfg_alt_src_i` are both 1, `cfg_err_o` is high on the next cycle, no start is issued and any pending request is dropped.
- R10: `cfg_mode_i` = 3 requests no starts.
- R11: `start_o` is a single-cycle pulse and is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_i | input | DATA_W | Word waiting to be serialized |
| trig_pin_i | input | 1 | Asynchronous hardware trigger |
| cfg_trig_pol_i | input | 1 | 0: rising edge active, 1: falling edge active |
| cfg_trig_en_i | input | 1 | Trigger pin enable |
| cfg_mode_i | input | 2 | 0 free-run, 1 trigger, 2 trigger-or-change, 3 hold |
| cfg_chain_en_i | input | 1 | Chained operation enable |
| cfg_is_master_i | input | 1 | 1: chain master, 0: chain slave |
| cfg_alt_src_i | input | 1 | Alternate serialization-source mode select |
| eng_busy_i | input | 1 | Transfer engine is busy |
| start_o | output | 1 | One-cycle frame start pulse |
| fwd_trig_o | output | 1 | Forwarded trigger toward the chain master |
| cfg_err_o | output | 1 | Chaining and alternate source both selected |

## Verification
The assertions assume that the configuration inputs and `eng_busy_i` are synchronous to `clk`, and that only `trig_pin_i` may change at arbitrary times. They also assume that the engine raises busy by its own choice and not in response to a forwarded trigger. The bench changes every input only at the falling clock edge and keeps the configuration steady for several cycles around each trigger edge. It drives busy as a plain level pattern, so every property sees clean sampled values. A behavioural model that tracks the pin history, the pending request and the last word is compared with all three outputs on every cycle.

// File: rtl/xtc_pkg.sv
package xtc_pkg;
  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_TRIG     = 2'd1,
    MODE_TRIG_CHG = 2'd2,
    MODE_HOLD     = 2'd3
  } xtc_mode_e;
endpackage

// File: rtl/xtc_trig_sync.sv
module xtc_trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic pol_i,
  input  logic en_i,
  output logic hit_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] stage_q;
  logic                   prev_q;
  logic                   rise, fall;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= 1'b0;
          else     stage_q[g] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= 1'b0;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= stage_q[LAST];
  end

  assign rise  = stage_q[LAST] & ~prev_q;
  assign fall  = ~stage_q[LAST] & prev_q;
  assign hit_o = en_i & (pol_i ? fall : rise);
endmodule

// File: rtl/xtc_chg_det.sv
module xtc_chg_det #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data_i,
  input  logic              load_i,
  output logic              changed_o
);
  logic [DATA_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst)         last_q <= '0;
    else if (load_i) last_q <= data_i;
  end

  assign changed_o = (data_i != last_q);
endmodule

// File: rtl/xtc_start_arb.sv
module xtc_start_arb
  import xtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  xtc_mode_e mode_i,
  input  logic      hit_i,
  input  logic      changed_i,
  input  logic      busy_i,
  input  logic      chain_en_i,
  input  logic      is_master_i,
  input  logic      alt_src_i,
  output logic      fire_o,
  output logic      start_o,
  output logic      fwd_o,
  output logic      err_o
);
  logic pend_q, start_q, fwd_q, err_q;
  logic req, bad_cfg;

  always_comb begin
    unique case (mode_i)
      MODE_FREE:     req = 1'b1;
      MODE_TRIG:     req = hit_i;
      MODE_TRIG_CHG: req = hit_i | changed_i;
      default:       req = 1'b0;
    endcase
  end

  assign bad_cfg = chain_en_i & alt_src_i;
  assign fire_o  = (pend_q | req) & ~busy_i & ~bad_cfg & ~start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      fwd_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      start_q <= fire_o;
      fwd_q   <= hit_i & chain_en_i & ~is_master_i;
      err_q   <= bad_cfg;
      if (fire_o || bad_cfg) pend_q <= 1'b0;
      else if (req)          pend_q <= 1'b1;
    end
  end

  assign start_o = start_q;
  assign fwd_o   = fwd_q;
  assign err_o   = err_q;
endmodule

// File: rtl/xtc_trig_ctrl.sv
module xtc_trig_ctrl
  import xtc_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data_i,
  input  logic              trig_pin_i,
  input  logic              cfg_trig_pol_i,
  input  logic              cfg_trig_en_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic              cfg_chain_en_i,
  input  logic              cfg_is_master_i,
  input  logic              cfg_alt_src_i,
  input  logic              eng_busy_i,
  output logic              start_o,
  output logic              fwd_trig_o,
  output logic              cfg_err_o
);
  logic hit, changed, fire;

  xtc_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_i (trig_pin_i),
    .pol_i (cfg_trig_pol_i),
    .en_i  (cfg_trig_en_i),
    .hit_o (hit)
  );

  xtc_chg_det #(.DATA_W(DATA_W)) u_chg (
    .clk       (clk),
    .rst       (rst),
    .data_i    (data_i),
    .load_i    (fire),
    .changed_o (changed)
  );

  xtc_start_arb u_arb (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (xtc_mode_e'(cfg_mode_i)),
    .hit_i       (hit),
    .changed_i   (changed),
    .busy_i      (eng_busy_i),
    .chain_en_i  (cfg_chain_en_i),
    .is_master_i (cfg_is_master_i),
    .alt_src_i   (cfg_alt_src_i),
    .fire_o      (fire),
    .start_o     (start_o),
    .fwd_o       (fwd_trig_o),
    .err_o       (cfg_err_o)
  );
endmodule

// File: rtl/xtc_checker.sv
module xtc_checker (
  input logic clk,
  input logic rst,
  input logic cfg_trig_en_i,
  input logic cfg_chain_en_i,
  input logic cfg_is_master_i,
  input logic cfg_alt_src_i,
  input logic eng_busy_i,
  input logic start_o,
  input logic fwd_trig_o,
  input logic cfg_err_o
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o); // R11

  AST_NO_START_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    start_o |-> !$past(eng_busy_i)); // R6

  AST_ERR_TRACKS_CFG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cfg_err_o == $past(cfg_chain_en_i & cfg_alt_src_i))); // R9

  AST_NO_START_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |-> !start_o); // R9

  AST_FWD_SLAVE_ONLY: assert property (@(posedge clk) disable iff (rst)
    fwd_trig_o |-> $past(cfg_chain_en_i & ~cfg_is_master_i)); // R8

  AST_FWD_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    fwd_trig_o |-> $past(cfg_trig_en_i)); // R4
endmodule

bind xtc_trig_ctrl xtc_checker u_xtc_chk (
  .clk             (clk),
  .rst             (rst),
  .cfg_trig_en_i   (cfg_trig_en_i),
  .cfg_chain_en_i  (cfg_chain_en_i),
  .cfg_is_master_i (cfg_is_master_i),
  .cfg_alt_src_i   (cfg_alt_src_i),
  .eng_busy_i      (eng_busy_i),
  .start_o         (start_o),
  .fwd_trig_o      (fwd_trig_o),
  .cfg_err_o       (cfg_err_o)
);

// File: tb/xtc_trig_ctrl_tb_top.sv
module xtc_trig_ctrl_tb_top;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] data = '0;
  logic pin = 1'b0, pol = 1'b0, ten = 1'b0, chain = 1'b0, mst = 1'b0, alt = 1'b0, busy = 1'b0;
  logic [1:0] mode = 2'd3;
  logic start_o, fwd_o, err_o;

  int n_chk = 0, n_bad = 0, cyc = 0, start_cnt = 0;
  string tag = "R1";

  always #10 clk = ~clk; // 50 MHz

  xtc_trig_ctrl #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .data_i(data), .trig_pin_i(pin),
    .cfg_trig_pol_i(pol), .cfg_trig_en_i(ten), .cfg_mode_i(mode),
    .cfg_chain_en_i(chain), .cfg_is_master_i(mst), .cfg_alt_src_i(alt),
    .eng_busy_i(busy), .start_o(start_o), .fwd_trig_o(fwd_o), .cfg_err_o(err_o)
  );

  // behavioural reference model: pin history queue, pending flag, last word
  bit hist[$];
  bit m_pend, m_start, m_fwd, m_err;
  logic [DW-1:0] m_last;

  always @(posedge clk) begin
    if (rst) begin
      hist = '{0, 0, 0};
      m_pend = 0; m_start = 0; m_fwd = 0; m_err = 0; m_last = '0;
    end else begin
      bit lvl, old, edge_seen, want, go, bad;
      lvl = hist[1]; old = hist[2];
      edge_seen = ten && (pol ? (!lvl && old) : (lvl && !old));
      bad = chain && alt;
      case (mode)
        2'd0: want = 1;
        2'd1: want = edge_seen;
        2'd2: want = edge_seen || (data != m_last);
        default: want = 0;
      endcase
      go = (m_pend || want) && !busy && !bad && !m_start;
      m_fwd = edge_seen && chain && !mst;
      m_err = bad;
      if (go) begin m_last = data; m_pend = 0; end
      else if (bad) m_pend = 0;
      else if (want) m_pend = 1;
      m_start = go;
      hist.push_front(pin);
      void'(hist.pop_back());
    end
  end

  task automatic check(string t, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d: actual %b expected %b", t, what, cyc, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      if (start_o === 1'b1) start_cnt++;
      check(tag, "start_o", start_o, m_start);
      check((tag == "R3" || tag == "R4") ? "R7" : tag, "fwd_trig_o", fwd_o, m_fwd);
      check(tag, "cfg_err_o", err_o, m_err);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
    summary();
  end

  initial begin
    // R1: reset state
    tag = "R1";
    step(3);
    check("R1", "start_o in reset", start_o, 1'b0);
    check("R1", "fwd_trig_o in reset", fwd_o, 1'b0);
    check("R1", "cfg_err_o in reset", err_o, 1'b0);
    rst = 1'b0; mode = 2'd2; data = '0;
    start_cnt = 0;
    step(6);
    check("R1", "no start for zero word after reset", start_cnt != 0, 1'b0);

    // R5: data change
    tag = "R5";
    data = 16'h0005; step(4);
    data = 16'h0005; step(3);
    data = 16'hA5A5; step(2);
    data = 16'h0001; step(4);

    // R2 / R11: free-running
    tag = "R2"; mode = 2'd0; step(10);
    tag = "R11"; busy = 1'b1; step(2); busy = 1'b0; step(5);

    // R3: trigger, rising then falling
    tag = "R3"; mode = 2'd1; ten = 1'b1; pol = 1'b0; step(4);
    pin = 1'b1; step(6); pin = 1'b0; step(6);
    pol = 1'b1; step(2); pin = 1'b1; step(6); pin = 1'b0; step(6);
    pol = 1'b0;

    // R4: trigger disabled
    tag = "R4"; ten = 1'b0; chain = 1'b1; start_cnt = 0; step(2);
    for (int k = 0; k < 3; k++) begin pin = 1'b1; step(4); pin = 1'b0; step(4); end
    check("R4", "starts with trigger disabled", start_cnt != 0, 1'b0);
    chain = 1'b0; ten = 1'b1;

    // R5: trigger in trigger-or-change mode with steady data
    tag = "R5"; mode = 2'd2; step(4);
    pin = 1'b1; step(6); pin = 1'b0; step(4);

    // R6: busy holds a request
    tag = "R6"; mode = 2'd1; busy = 1'b1; step(2);
    pin = 1'b1; step(8); busy = 1'b0; step(4);
    busy = 1'b1; pin = 1'b0; step(1); pin = 1'b1; step(1); pin = 1'b0; step(6); busy = 1'b0; step(4);

    // R7: chained slave forwards triggers
    tag = "R7"; chain = 1'b1; mst = 1'b0; step(2);
    pin = 1'b1; step(6); pin = 1'b0; step(2);
    pol = 1'b1; step(6); pol = 1'b0; step(2);

    // R8: master and unchained do not forward
    tag = "R8"; mst = 1'b1; pin = 1'b1; step(6); pin = 1'b0; step(3);
    chain = 1'b0; mst = 1'b0; pin = 1'b1; step(6); pin = 1'b0; step(3);

    // R9: configuration error
    tag = "R9"; chain = 1'b1; busy = 1'b1; pin = 1'b1; step(5);
    alt = 1'b1; step(3); busy = 1'b0; mode = 2'd0; step(6);
    alt = 1'b0; step(4);
    alt = 1'b1; chain = 1'b0; step(3);
    alt = 1'b0; pin = 1'b0; step(2);

    // R10: hold mode
    tag = "R10"; mode = 2'd3; step(2); start_cnt = 0;
    data = 16'h1234; pin = 1'b1; step(6); pin = 1'b0; step(6);
    check("R10", "starts in hold mode", start_cnt != 0, 1'b0);

    // mid-run reset clears the last word (R1)
    tag = "R1"; mode = 2'd2; data = 16'h7777; step(3);
    rst = 1'b1; step(2); rst = 1'b0; data = '0; step(5);
    data = 16'h0002; step(4);

    summary();
  end
endmodule